// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serializer

This block places one stereo sample pair per frame onto a single serial data line. The bit clock and the left/right clock come from outside the block. The block changes its data output on bit-clock falling edges, so a receiver can take each bit on the next rising edge. Static inputs select the framing and the word length. The supported framings are:

- left aligned to the channel edge
- right aligned to the channel edge
- delayed by one bit (I2S)
- two short-sync formats, in which a one-cycle pulse on the left/right clock starts each frame

At the start of every left channel or frame, the block copies the parallel sample pair into a holding register. Both words sent in that frame therefore come from the same sample. Two conditions are reported. An unsupported combination of format and word length is shown on a live flag, and the data line is held low while it lasts. A channel or frame too short for the chosen word sets a sticky error flag, and the word that did not fit is cut short.

The block samples the left/right clock on each bit-clock falling edge. A level that differs from the previous sample counts as a transition at that edge. The data output updates on that same edge.

Top module: `audio_serializer`

## Requirements
- R1: While reset is held, and after reset until the first transition of the left/right clock, `dout_o` and `short_err_o` are 0.
- R2: Words go out MSB first. `wl_i` selects the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. The word is the top bits of the 32-bit sample input, so bit 31 is the MSB. Every bit slot outside a word is driven 0.
- R3: With `fmt_i`=0 (left aligned), a high left/right clock selects the left channel and a low one selects the right. The MSB is driven on the same falling edge at which the new level is first sampled.
- R4: With `fmt_i`=2 (I2S), channel selection is as in R3, and the MSB is driven one bit clock after the transition edge.
- R5: With `fmt_i`=1 (right aligned), the LSB occupies the last bit clock of the channel. The channel length is taken from the previous phase of the same channel. Until such a previous phase has been measured, that channel's slots are driven 0.
- R6: With `fmt_i`=4 (late sync), a rising edge of the left/right clock starts a frame. The left MSB is driven at that edge, and the right word follows the left LSB directly.
- R7: With `fmt_i`=3 (early sync), the layout is as in R6 but shifted one bit clock later.
- R8: At the start of the left channel (R3 to R5) or of the frame (R6, R7), the block captures both sample inputs. Changes to the inputs later in the frame do not affect the words sent in that frame.
- R9: `short_err_o` is set, and then stays set until reset, when an interval ends too early. For R3 and R5 this means a channel shorter than the word length. For R4 it means a channel shorter than the word length plus one. For R6 and R7 it means a frame shorter than twice the word length plus the sync offset. A word that runs past the end of its interval is truncated.
- R10: `cfg_err_o` is 1 when `fmt_i` is greater than 4, or when `fmt_i`=1 with `wl_i`=3. While it is 1, `dout_o` is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; the block acts on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrclk_i | input | 1 | Left/right clock or frame sync |
| fmt_i | input | 3 | Framing select (see R3 to R7) |
| wl_i | input | 2 | Word length select (see R2) |
| left_i | input | DW | Left sample, MSB aligned |
| right_i | input | DW | Right sample, MSB aligned |
| dout_o | output | 1 | Serial data |
| cfg_err_o | output | 1 | Unsupported configuration |
| short_err_o | output | 1 | Sticky short-interval error |

## Verification
Two events can land on the same falling edge: the end of a too-short right channel, and the start of the next left channel. At that edge the block must set the sticky error, capture a new sample pair and drive the new left MSB, all at once. Directed left-aligned runs provoke this by ending a right channel early. The random runs also shorten channels and frames now and then. The bench then expects, on that one edge, the error flag set and the data bit equal to the MSB of the pair applied at that edge, not the pair held from before.

// File: rtl/audser_pkg.sv
package audser_pkg;
  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPE = 3'd3,
    FMT_DSPL = 3'd4
  } fmt_e;

  function automatic logic [5:0] word_len(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/audser_timing.sv
module audser_timing #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrclk_i,
  input  logic             frame_mode_i,
  output logic             edge_o,
  output logic             rise_o,
  output logic             seen_o,
  output logic             lr_prev_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] len_end_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             lr_q, seen_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    rise_o    = lrclk_i & ~lr_q;
    edge_o    = frame_mode_i ? rise_o : (lrclk_i ^ lr_q);
    len_end_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    cnt_o     = edge_o ? '0 : len_end_o;
    seen_o    = seen_q;
    lr_prev_o = lr_q;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q   <= 1'b0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      lr_q  <= lrclk_i;
      cnt_q <= cnt_o;
      if (edge_o) seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/audser_len_hist.sv
module audser_len_hist #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             store_i,
  input  logic             wr_ch_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             rd_ch_i,
  output logic [CNT_W-1:0] len_o,
  output logic             vld_o
);
  // one measured phase length per channel (index 1 = left)
  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [CNT_W-1:0] len_r;
    logic             vld_r;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_r <= '0;
        vld_r <= 1'b0;
      end else if (store_i && (wr_ch_i == 1'(g))) begin
        len_r <= len_i;
        vld_r <= 1'b1;
      end
    end
  end

  assign len_o = rd_ch_i ? g_ch[1].len_r : g_ch[0].len_r;
  assign vld_o = rd_ch_i ? g_ch[1].vld_r : g_ch[0].vld_r;
endmodule

// File: rtl/audser_bitsel.sv
module audser_bitsel
  import audser_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 9
) (
  input  logic [2:0]       fmt_i,
  input  logic [1:0]       wl_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             lr_i,
  input  logic [CNT_W-1:0] prev_len_i,
  input  logic             prev_vld_i,
  input  logic [DW-1:0]    left_i,
  input  logic [DW-1:0]    right_i,
  output logic             bit_o
);
  logic [CNT_W-1:0] wl, wl2, off, pos;
  logic             ok, dsp;
  logic [DW-1:0]    word, sh;

  always_comb begin
    wl   = CNT_W'(word_len(wl_i));
    wl2  = wl << 1;
    ok   = 1'b1;
    dsp  = 1'b0;
    off  = '0;
    case (fmt_i)
      FMT_I2S:  off = CNT_W'(1);
      FMT_RJ: begin
        ok  = prev_vld_i && (prev_len_i >= wl);
        off = prev_len_i - wl;
      end
      FMT_DSPE: begin
        dsp = 1'b1;
        off = CNT_W'(1);
      end
      FMT_DSPL: dsp = 1'b1;
      default:  off = '0;
    endcase

    pos   = cnt_i - off;
    word  = lr_i ? left_i : right_i;
    sh    = '0;
    bit_o = 1'b0;
    if (ok && (cnt_i >= off)) begin
      if (!dsp) begin
        if (pos < wl) begin
          sh    = word << pos;
          bit_o = sh[DW-1];
        end
      end else if (pos < wl) begin
        sh    = left_i << pos;
        bit_o = sh[DW-1];
      end else if (pos < wl2) begin
        sh    = right_i << (pos - wl);
        bit_o = sh[DW-1];
      end
    end
  end
endmodule

// File: rtl/audio_serializer.sv
module audio_serializer
  import audser_pkg::*;
#(
  parameter int DW        = 32,   // sample input width, at least 32
  parameter int MAX_PHASE = 256   // longest interval measured exactly
) (
  input  logic          bclk_i,
  input  logic          rst_ni,
  input  logic          lrclk_i,
  input  logic [2:0]    fmt_i,
  input  logic [1:0]    wl_i,
  input  logic [DW-1:0] left_i,
  input  logic [DW-1:0] right_i,
  output logic          dout_o,
  output logic          cfg_err_o,
  output logic          short_err_o
);
  localparam int CNT_W = $clog2(MAX_PHASE) + 1;

  logic             dsp, edge_s, rise_s, seen_s, lr_prev;
  logic [CNT_W-1:0] cnt, len_end, prev_len, wl, need;
  logic             prev_vld, bit_s, err_set, store;
  logic [DW-1:0]    hold_l, hold_r, smp_l, smp_r;
  logic             dout_q, err_q;

  assign dsp = (fmt_i == FMT_DSPE) || (fmt_i == FMT_DSPL);
  assign cfg_err_o = (fmt_i > 3'd4) || ((fmt_i == FMT_RJ) && (wl_i == 2'd3));

  audser_timing #(.CNT_W(CNT_W)) u_timing (
    .clk_i       (bclk_i),
    .rst_ni      (rst_ni),
    .lrclk_i     (lrclk_i),
    .frame_mode_i(dsp),
    .edge_o      (edge_s),
    .rise_o      (rise_s),
    .seen_o      (seen_s),
    .lr_prev_o   (lr_prev),
    .cnt_o       (cnt),
    .len_end_o   (len_end)
  );

  assign store = edge_s && seen_s && !dsp;

  audser_len_hist #(.CNT_W(CNT_W)) u_hist (
    .clk_i  (bclk_i),
    .rst_ni (rst_ni),
    .store_i(store),
    .wr_ch_i(lr_prev),
    .len_i  (len_end),
    .rd_ch_i(lrclk_i),
    .len_o  (prev_len),
    .vld_o  (prev_vld)
  );

  // new pair is used directly on the capture edge
  assign smp_l = rise_s ? left_i  : hold_l;
  assign smp_r = rise_s ? right_i : hold_r;

  audser_bitsel #(.DW(DW), .CNT_W(CNT_W)) u_bitsel (
    .fmt_i     (fmt_i),
    .wl_i      (wl_i),
    .cnt_i     (cnt),
    .lr_i      (lrclk_i),
    .prev_len_i(prev_len),
    .prev_vld_i(prev_vld),
    .left_i    (smp_l),
    .right_i   (smp_r),
    .bit_o     (bit_s)
  );

  always_comb begin
    wl = CNT_W'(word_len(wl_i));
    if (dsp) need = (wl << 1) + CNT_W'(fmt_i == FMT_DSPE);
    else     need = wl + CNT_W'(fmt_i == FMT_I2S);
  end

  assign err_set = edge_s && seen_s && (len_end < need) && !cfg_err_o;

  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l <= '0;
      hold_r <= '0;
      dout_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (rise_s) begin
        hold_l <= left_i;
        hold_r <= right_i;
      end
      dout_q <= !cfg_err_o && (seen_s || edge_s) && bit_s;
      err_q  <= err_q | err_set;
    end
  end

  assign dout_o      = dout_q;
  assign short_err_o = err_q;
endmodule

// File: rtl/audio_serializer_chk.sv
module audio_serializer_chk
  import audser_pkg::*;
(
  input logic       bclk_i,
  input logic       rst_ni,
  input logic       lrclk_i,
  input logic [2:0] fmt_i,
  input logic       left_msb_i,
  input logic       dout_o,
  input logic       cfg_err_o,
  input logic       short_err_o
);
  AST_LJ_MSB_AT_EDGE: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    (fmt_i == FMT_LJ && $rose(lrclk_i)) |=> (dout_o == $past(left_msb_i))); // R3

  AST_I2S_GAP_BIT: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    (fmt_i == FMT_I2S && !$stable(lrclk_i)) |=> !dout_o); // R4

  AST_DSPL_MSB_AT_SYNC: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    (fmt_i == FMT_DSPL && $rose(lrclk_i)) |=> (dout_o == $past(left_msb_i))); // R6

  AST_ERR_STICKY: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    $past(short_err_o) |-> short_err_o); // R9

  AST_CFG_SILENT: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    (cfg_err_o && $past(cfg_err_o)) |-> !dout_o); // R10
endmodule

bind audio_serializer audio_serializer_chk u_chk (
  .bclk_i     (bclk_i),
  .rst_ni     (rst_ni),
  .lrclk_i    (lrclk_i),
  .fmt_i      (fmt_i),
  .left_msb_i (left_i[DW-1]),
  .dout_o     (dout_o),
  .cfg_err_o  (cfg_err_o),
  .short_err_o(short_err_o)
);

// File: tb/audio_serializer_test.sv
module audio_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          bclk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lrclk = 1'b0;
  logic [2:0]    fmt = 3'd0;
  logic [1:0]    wl = 2'd0;
  logic [DW-1:0] left = '0, right = '0;
  logic          dout, cfg_err, short_err;

  int checks = 0, errors = 0;
  // bench model
  int   wlen, run_len;
  bit   seen, exp_err, cfg_bad;
  int   plen[2];
  bit   pvld[2];
  logic [31:0] hold_l, hold_r;

  audio_serializer #(.DW(DW)) uut (
    .bclk_i(bclk), .rst_ni(rst_ni), .lrclk_i(lrclk), .fmt_i(fmt), .wl_i(wl),
    .left_i(left), .right_i(right), .dout_o(dout), .cfg_err_o(cfg_err),
    .short_err_o(short_err)
  );

  always #(CLK_PERIOD/2) bclk = ~bclk;

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int len_of(input logic [1:0] c);
    case (c) 2'd0: return 16; 2'd1: return 20; 2'd2: return 24; default: return 32; endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (f) 3'd0: return "R3/R2/R8"; 3'd1: return "R5/R2/R8"; 3'd2: return "R4/R2/R8";
      3'd3: return "R7/R2/R8"; 3'd4: return "R6/R2/R8"; default: return "R10"; endcase
  endfunction

  function automatic logic std_exp(input logic [2:0] f, input int w, input int idx,
                                   input int pl, input bit pv, input logic [31:0] word);
    int off = 0;
    if (f == 3'd2) off = 1;
    if (f == 3'd1) begin
      if (!pv || pl < w) return 1'b0;
      off = pl - w;
    end
    if (idx >= off && idx - off < w) return word[31 - (idx - off)];
    return 1'b0;
  endfunction

  function automatic logic dsp_exp(input int early, input int w, input int idx,
                                   input logic [31:0] l, input logic [31:0] r);
    int p = idx - early;
    if (p < 0) return 1'b0;
    if (p < w) return l[31 - p];
    if (p < 2 * w) return r[31 - (p - w)];
    return 1'b0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bit_step(input logic lr, input logic exp_d);
    lrclk = lr;
    @(negedge bclk);
    @(posedge bclk);
    chk(32'(dout), 32'(cfg_bad ? 1'b0 : exp_d), cfg_bad ? "R10" : tag_of(fmt));
    if (!cfg_bad) chk(32'(short_err), 32'(exp_err), "R9");
  endtask

  task automatic do_reset(input logic [2:0] f, input logic [1:0] w);
    rst_ni = 1'b0;
    lrclk = 1'b0;
    fmt = f;
    wl = w;
    repeat (2) @(posedge bclk);
    chk(32'(dout), 32'd0, "R1");
    chk(32'(short_err), 32'd0, "R1");
    rst_ni = 1'b1;
    wlen = len_of(w);
    cfg_bad = (f > 3'd4) || (f == 3'd1 && w == 2'd3);
    seen = 0; exp_err = 0; run_len = 0;
    plen[0] = 0; plen[1] = 0; pvld[0] = 0; pvld[1] = 0;
  endtask

  task automatic warmup(input int n);
    for (int i = 0; i < n; i++) begin
      lrclk = 1'b0;
      @(negedge bclk);
      @(posedge bclk);
      chk(32'(dout), 32'd0, "R1");
    end
  endtask

  task automatic std_phase(input bit lr, input int len);
    int need = wlen + ((fmt == 3'd2) ? 1 : 0);
    if (seen) begin
      if (run_len < need) exp_err = 1;
      plen[!lr] = run_len;
      pvld[!lr] = 1;
    end
    seen = 1;
    if (lr) begin
      hold_l = $urandom; hold_r = $urandom;
      left = hold_l; right = hold_r;
    end
    for (int i = 0; i < len; i++) begin
      if (i == 2) begin left = $urandom; right = $urandom; end
      bit_step(lr, std_exp(fmt, wlen, i, plen[lr], pvld[lr], lr ? hold_l : hold_r));
    end
    run_len = len;
  endtask

  task automatic dsp_frame(input int len);
    int early = (fmt == 3'd3) ? 1 : 0;
    if (seen && run_len < 2 * wlen + early) exp_err = 1;
    seen = 1;
    hold_l = $urandom; hold_r = $urandom;
    left = hold_l; right = hold_r;
    for (int i = 0; i < len; i++) begin
      if (i == 2) begin left = $urandom; right = $urandom; end
      bit_step(i == 0, dsp_exp(early, wlen, i, hold_l, hold_r));
    end
    run_len = len;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(posedge bclk);

    // R1 reset state, then R3 left aligned with uneven mark/space
    do_reset(3'd0, 2'd0);
    chk(32'(cfg_err), 32'd0, "R10");
    warmup(3);
    std_phase(1, 20); std_phase(0, 16); std_phase(1, 16); std_phase(0, 30);

    // R9 short left channel truncates and sets the sticky flag
    do_reset(3'd0, 2'd2);
    warmup(2);
    std_phase(1, 30); std_phase(0, 24); std_phase(1, 20); std_phase(0, 26);
    std_phase(1, 24);
    chk(32'(short_err), 32'd1, "R9");

    // R9 + R8 same edge: short right channel ends where a new left begins
    do_reset(3'd0, 2'd0);
    warmup(2);
    std_phase(1, 18); std_phase(0, 10); std_phase(1, 17); std_phase(0, 16);

    // R5 right aligned: first frame silent, then flush to the channel end
    do_reset(3'd1, 2'd1);
    warmup(2);
    std_phase(1, 40); std_phase(0, 26); std_phase(1, 40); std_phase(0, 26);
    std_phase(1, 20); std_phase(0, 21);

    // R4 I2S at exact minimum length (word + 1)
    do_reset(3'd2, 2'd3);
    warmup(2);
    std_phase(1, 33); std_phase(0, 33); std_phase(1, 40); std_phase(0, 32);
    std_phase(1, 33);

    // R6 / R7 short-sync frames including one short frame
    do_reset(3'd4, 2'd0);
    warmup(2);
    dsp_frame(32); dsp_frame(40); dsp_frame(20); dsp_frame(32);
    do_reset(3'd3, 2'd2);
    warmup(2);
    dsp_frame(49); dsp_frame(60); dsp_frame(49);

    // R10 unsupported configurations keep the line low
    do_reset(3'd1, 2'd3);
    chk(32'(cfg_err), 32'd1, "R10");
    warmup(1);
    std_phase(1, 40); std_phase(0, 40); std_phase(1, 40);
    do_reset(3'd6, 2'd0);
    chk(32'(cfg_err), 32'd1, "R10");
    warmup(1);
    std_phase(1, 20); std_phase(0, 20);

    // constrained random mix
    for (int t = 0; t < 40; t++) begin
      logic [2:0] f;
      logic [1:0] w;
      f = 3'($urandom_range(0, 4));
      w = 2'($urandom_range(0, 3));
      if (f == 3'd1 && w == 2'd3) w = 2'd2;
      do_reset(f, w);
      warmup(int'($urandom_range(1, 4)));
      for (int k = 0; k < 3; k++) begin
        if (f >= 3'd3) begin
          int mn = 2 * wlen + ((f == 3'd3) ? 1 : 0);
          int ln = mn + int'($urandom_range(0, 8));
          if ($urandom_range(0, 9) == 0) ln = mn - int'($urandom_range(1, 4));
          dsp_frame(ln);
        end else begin
          int mn = wlen + ((f == 3'd2) ? 1 : 0);
          for (int ph = 1; ph >= 0; ph--) begin
            int ln = mn + int'($urandom_range(0, 6));
            if ($urandom_range(0, 9) == 0) ln = mn - int'($urandom_range(1, 3));
            std_phase(ph[0], ln);
          end
        end
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule